// File: doc/BRIEF.md
# Current-Fault Delay Qualifier

This block sits between three current comparators in a battery pack and the pack's charge and discharge switch drivers. Each comparator presents a synchronous flag: sustained discharge overcurrent, discharge short circuit, and charge short circuit. The block gates each flag through its own programmable hold-off timer. A fault is latched only once its flag has stayed high for the programmed time. A latched fault then opens the switch on the same side as the current direction. Charge faults open the charge switch and leave discharge alone, and discharge faults do the opposite.

All timing runs from one tick enable, nominally one microsecond. Each channel turns a small delay code into a tick count by multiplying the code by a per-channel step. The two short-circuit channels use steps of tens of microseconds. The overcurrent channel uses a millisecond-scale base plus a step. A doubling control stretches the discharge short-circuit window and no other. A sense-range select halves the threshold scale. The block exports the resulting threshold magnitudes as digital codes for the analog comparators. The host clears each latched fault on its own channel through a clear strobe.

Top module: `pack_fault_qualifier`

## Requirements
- R1: After reset all three fault outputs are 0 and both switch enables are 1.
- R2: Discharge short-circuit channel (fault bit 1): with the doubling control clear and the flag held high, the fault latches on the tick where the count of ticks reaches code x SC_STEP_TICKS. A code of 0 latches at the first clock edge that samples the flag high, with or without a tick.
- R3: With the doubling control set, the discharge short-circuit limit becomes 2 x code x SC_STEP_TICKS ticks.
- R4: Charge short-circuit channel (fault bit 2): the limit is code x SC_STEP_TICKS ticks whatever the doubling control is.
- R5: Discharge overcurrent channel (fault bit 0): the limit is OC_BASE_TICKS + code x OC_STEP_TICKS ticks, so it is never zero.
- R6: If a flag drops before its limit is reached, that channel's count returns to zero and no fault latches. A later assertion needs the full limit again.
- R7: A latched fault stays set until its clear strobe is sampled while its flag is low. A clear sampled while the flag is high is ignored.
- R8: Fault bit 2 drives only the charge-switch enable low. Fault bits 0 and 1 drive only the discharge-switch enable low.
- R9: Overcurrent threshold export (4-bit code k): 50 + 10k mV with the range select clear, 25 + 5k mV with it set.
- R10: Charge short-circuit threshold magnitude export (3-bit code k): 100 + 50k mV with k clamped to 4 when the range select is clear, and 50 + 25k mV when it is set.
- R11: Counting advances only on clock edges where the tick enable is high. With ticks every P cycles starting at the first flagged edge, a nonzero limit L latches at edge 1 + (L-1)P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one clock wide |
| flag_i | input | 3 | Comparator flags: bit0 overcurrent discharge, bit1 short discharge, bit2 short charge |
| clr_i | input | 3 | Per-channel clear strobes, same bit order |
| cfg_ocd_code_i | input | 4 | Overcurrent delay code |
| cfg_scd_code_i | input | 4 | Discharge short-circuit delay code |
| cfg_scc_code_i | input | 4 | Charge short-circuit delay code |
| cfg_dbl_i | input | 1 | Doubles the discharge short-circuit delay |
| cfg_range_i | input | 1 | Halves the threshold scale when set |
| cfg_ocd_thr_i | input | 4 | Overcurrent threshold code |
| cfg_scc_thr_i | input | 3 | Charge short-circuit threshold code |
| fault_o | output | 3 | Latched faults, same bit order as flag_i |
| chg_en_o | output | 1 | Charge switch enable (0 opens switch) |
| dsg_en_o | output | 1 | Discharge switch enable (0 opens switch) |
| ocd_thr_mv_o | output | 8 | Overcurrent threshold in mV |
| scc_thr_mv_o | output | 9 | Charge short-circuit threshold magnitude in mV |

## Verification
The hardest state to reach is a timer cut off one tick short of its limit. The flag must stay high for exactly L-1 counted ticks and then fall, and a fresh assertion must then show that the full limit applies again. The bench builds this with a tick-accurate drive loop. It holds the flag for the computed number of edges, checks that no fault has appeared, drops the flag for one cycle and measures the delay from scratch. Sparse ticks, with one tick every three cycles, are driven the same way to separate tick counting from clock counting.

// File: rtl/pfq_pkg.sv
// Shared constants for the current-fault delay qualifier.
// Assumes three channels with fixed bit positions used across the block.
package pfq_pkg;
    localparam int NUM_CH     = 3;
    localparam int CH_OCD     = 0;   // discharge overcurrent
    localparam int CH_SCD     = 1;   // discharge short circuit
    localparam int CH_SCC     = 2;   // charge short circuit
    localparam int CODE_W     = 4;
    localparam int OCD_THR_W  = 4;
    localparam int SCC_THR_W  = 3;
    localparam int OCD_MV_W   = 8;
    localparam int SCC_MV_W   = 9;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pfq_delay_chan.sv
// One hold-off timer. Counts ticks while the flag is high, latches a fault
// when the count reaches the limit, and holds it until a clear strobe is
// sampled with the flag low. Assumes limit is stable while counting.
module pfq_delay_chan #(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             flag_i,
    input  logic             clr_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             fault_o
);
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W:0]   cnt_next;
    logic             expire;

    // Next count and expiry test.
    always_comb begin
        cnt_next = {1'b0, cnt_q} + {{LIM_W{1'b0}}, 1'b1};
        expire   = (limit_i == '0) || (tick_i && (cnt_next >= {1'b0, limit_i}));
    end

    // Tick counter: cleared whenever the flag is low, frozen once latched.
    always_ff @(posedge clk) begin
        if (!rst_n || !flag_i) begin
            cnt_q <= '0;
        end else if (!fault_o && tick_i && !expire) begin
            cnt_q <= cnt_next[LIM_W-1:0];
        end
    end

    // Fault latch: set on expiry with flag high, cleared by strobe with flag low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o <= 1'b0;
        end else if (flag_i && expire) begin
            fault_o <= 1'b1;
        end else if (!flag_i && clr_i) begin
            fault_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pfq_thr_map.sv
// Maps threshold codes to millivolt magnitudes for the comparators.
// The range select halves the scale. The charge short-circuit code saturates
// at the top of the full-scale range.
module pfq_thr_map
    import pfq_pkg::*;
#(
    parameter int OCD_BASE_MV = 50,
    parameter int OCD_STEP_MV = 10,
    parameter int SCC_BASE_MV = 100,
    parameter int SCC_STEP_MV = 50,
    parameter int SCC_MAX_K   = 4
) (
    input  logic                 range_i,
    input  logic [OCD_THR_W-1:0] ocd_code_i,
    input  logic [SCC_THR_W-1:0] scc_code_i,
    output logic [OCD_MV_W-1:0]  ocd_mv_o,
    output logic [SCC_MV_W-1:0]  scc_mv_o
);
    localparam int OCD_BASE_H = OCD_BASE_MV / 2;
    localparam int OCD_STEP_H = OCD_STEP_MV / 2;
    localparam int SCC_BASE_H = SCC_BASE_MV / 2;
    localparam int SCC_STEP_H = SCC_STEP_MV / 2;

    int ocd_k;
    int scc_k;
    int ocd_v;
    int scc_v;

    // Code-to-millivolt arithmetic for both thresholds.
    always_comb begin
        ocd_k = int'(ocd_code_i);
        scc_k = int'(scc_code_i);
        if (range_i) begin
            ocd_v = OCD_BASE_H + ocd_k * OCD_STEP_H;
            scc_v = SCC_BASE_H + scc_k * SCC_STEP_H;
        end else begin
            if (scc_k > SCC_MAX_K) scc_k = SCC_MAX_K;
            ocd_v = OCD_BASE_MV + ocd_k * OCD_STEP_MV;
            scc_v = SCC_BASE_MV + scc_k * SCC_STEP_MV;
        end
        ocd_mv_o = ocd_v[OCD_MV_W-1:0];
        scc_mv_o = scc_v[SCC_MV_W-1:0];
    end
endmodule

// File: rtl/pack_fault_qualifier.sv
// Top of the current-fault delay qualifier. Derives the per-channel tick limits
// from the delay codes, runs one timer per channel and maps the latched
// faults onto the charge and discharge switch enables.
// Assumes tick_i is one clock wide and that the flags are already synchronous.
module pack_fault_qualifier
    import pfq_pkg::*;
#(
    parameter int SC_STEP_TICKS  = 61,
    parameter int OC_BASE_TICKS  = 1000,
    parameter int OC_STEP_TICKS  = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [2:0]           flag_i,
    input  logic [2:0]           clr_i,
    input  logic [3:0]           cfg_ocd_code_i,
    input  logic [3:0]           cfg_scd_code_i,
    input  logic [3:0]           cfg_scc_code_i,
    input  logic                 cfg_dbl_i,
    input  logic                 cfg_range_i,
    input  logic [3:0]           cfg_ocd_thr_i,
    input  logic [2:0]           cfg_scc_thr_i,
    output logic [2:0]           fault_o,
    output logic                 chg_en_o,
    output logic                 dsg_en_o,
    output logic [7:0]           ocd_thr_mv_o,
    output logic [8:0]           scc_thr_mv_o
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int SC_MAX   = 2 * CODE_MAX * SC_STEP_TICKS;
    localparam int OC_MAX   = OC_BASE_TICKS + CODE_MAX * OC_STEP_TICKS;
    localparam int LIM_W    = $clog2(max2(SC_MAX, OC_MAX) + 1);

    logic [LIM_W-1:0] limit [NUM_CH];
    logic [LIM_W-1:0] sc_unit;
    logic [LIM_W-1:0] oc_base;
    logic [LIM_W-1:0] oc_step;

    assign sc_unit = LIM_W'(SC_STEP_TICKS);
    assign oc_base = LIM_W'(OC_BASE_TICKS);
    assign oc_step = LIM_W'(OC_STEP_TICKS);

    // Per-channel limit arithmetic; doubling affects discharge short only.
    always_comb begin
        limit[CH_OCD] = oc_base + LIM_W'(cfg_ocd_code_i) * oc_step;
        limit[CH_SCD] = LIM_W'(cfg_scd_code_i) * sc_unit;
        if (cfg_dbl_i) limit[CH_SCD] = limit[CH_SCD] << 1;
        limit[CH_SCC] = LIM_W'(cfg_scc_code_i) * sc_unit;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pfq_delay_chan #(.LIM_W(LIM_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .flag_i  (flag_i[g]),
            .clr_i   (clr_i[g]),
            .limit_i (limit[g]),
            .fault_o (fault_o[g])
        );
    end

    // Switch enables follow the current direction of each fault.
    always_comb begin
        chg_en_o = !fault_o[CH_SCC];
        dsg_en_o = !(fault_o[CH_OCD] || fault_o[CH_SCD]);
    end

    pfq_thr_map thr_i (
        .range_i    (cfg_range_i),
        .ocd_code_i (cfg_ocd_thr_i),
        .scc_code_i (cfg_scc_thr_i),
        .ocd_mv_o   (ocd_thr_mv_o),
        .scc_mv_o   (scc_thr_mv_o)
    );
endmodule

// File: rtl/pfq_checker.sv
// Temporal checks on the qualifier's ports, bound to every instance of the top.
module pfq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] flag_i,
    input logic [2:0] clr_i,
    input logic [3:0] cfg_scd_code_i,
    input logic [2:0] fault_o,
    input logic       chg_en_o,
    input logic       dsg_en_o,
    input logic [7:0] ocd_thr_mv_o
);
    for (genvar i = 0; i < 3; i++) begin : g_ch
        // R7
        fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault_o[i] && !(clr_i[i] && !flag_i[i]) |=> fault_o[i]);
        // R7
        clear_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fault_o[i]) |-> ($past(clr_i[i]) && !$past(flag_i[i])));
        // R6
        rise_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_o[i]) |-> $past(flag_i[i]));
    end

    // R2
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_i[1] && (cfg_scd_code_i == 4'd0) && !fault_o[1] |=> fault_o[1]);
    // R8
    chg_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o[2]) && !fault_o[0] && !fault_o[1] |-> dsg_en_o && !chg_en_o);
    // R8
    dsg_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_o[0]) || $rose(fault_o[1])) && !fault_o[2] |-> chg_en_o && !dsg_en_o);
    // R9
    ocd_thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocd_thr_mv_o >= 8'd25) && (ocd_thr_mv_o <= 8'd200));
endmodule

bind pack_fault_qualifier pfq_checker chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .flag_i         (flag_i),
    .clr_i          (clr_i),
    .cfg_scd_code_i (cfg_scd_code_i),
    .fault_o        (fault_o),
    .chg_en_o       (chg_en_o),
    .dsg_en_o       (dsg_en_o),
    .ocd_thr_mv_o   (ocd_thr_mv_o)
);

// File: tb/pack_fault_qualifier_tb_top.sv
// Sweeps every delay code of every channel in a small tick configuration and
// compares the latch edge against arithmetic expectations.
module pack_fault_qualifier_tb_top;
    localparam int SC_STEP = 3;
    localparam int OC_BASE = 2;
    localparam int OC_STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [2:0] flag_i = '0;
    logic [2:0] clr_i = '0;
    logic [3:0] cfg_ocd_code_i = '0;
    logic [3:0] cfg_scd_code_i = '0;
    logic [3:0] cfg_scc_code_i = '0;
    logic       cfg_dbl_i = 1'b0;
    logic       cfg_range_i = 1'b0;
    logic [3:0] cfg_ocd_thr_i = '0;
    logic [2:0] cfg_scc_thr_i = '0;
    logic [2:0] fault_o;
    logic       chg_en_o;
    logic       dsg_en_o;
    logic [7:0] ocd_thr_mv_o;
    logic [8:0] scc_thr_mv_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pack_fault_qualifier #(
        .SC_STEP_TICKS (SC_STEP),
        .OC_BASE_TICKS (OC_BASE),
        .OC_STEP_TICKS (OC_STEP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .flag_i(flag_i), .clr_i(clr_i),
        .cfg_ocd_code_i(cfg_ocd_code_i), .cfg_scd_code_i(cfg_scd_code_i),
        .cfg_scc_code_i(cfg_scc_code_i), .cfg_dbl_i(cfg_dbl_i), .cfg_range_i(cfg_range_i),
        .cfg_ocd_thr_i(cfg_ocd_thr_i), .cfg_scc_thr_i(cfg_scc_thr_i),
        .fault_o(fault_o), .chg_en_o(chg_en_o), .dsg_en_o(dsg_en_o),
        .ocd_thr_mv_o(ocd_thr_mv_o), .scc_thr_mv_o(scc_thr_mv_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Raise one flag and count edges until its fault appears, then clear it.
    task automatic measure(input int ch, input int per, input int lim, input string req);
        int n = 0;
        int exp_n;
        exp_n = (lim == 0) ? 1 : 1 + (lim - 1) * per;
        @(negedge clk);
        flag_i[ch] = 1'b1;
        tick_i = 1'b1;
        while (n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (fault_o[ch]) break;
            tick_i = ((n % per) == 0);
        end
        check(req, n, exp_n);
        // R8: direction-specific switch response
        check("R8 chg_en", int'(chg_en_o), (ch == 2) ? 0 : 1);
        check("R8 dsg_en", int'(dsg_en_o), (ch == 2) ? 1 : 0);
        flag_i[ch] = 1'b0;
        clr_i[ch] = 1'b1;
        tick_i = 1'b1;
        @(negedge clk);
        clr_i[ch] = 1'b0;
        check("R7 cleared", int'(fault_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 fault", int'(fault_o), 0);
        check("R1 chg_en", int'(chg_en_o), 1);
        check("R1 dsg_en", int'(dsg_en_o), 1);
        rst_n = 1'b1;

        for (int d = 0; d < 2; d++) begin
            cfg_dbl_i = d[0];
            for (int c = 0; c < 16; c++) begin
                cfg_scd_code_i = c[3:0];
                cfg_scc_code_i = c[3:0];
                // R2 / R3: discharge short delay, doubled when set
                measure(1, 1, c * SC_STEP * (d + 1), (d == 0) ? "R2 scd delay" : "R3 scd doubled");
                // R4: charge short delay ignores doubling
                measure(2, 1, c * SC_STEP, "R4 scc delay");
            end
        end
        cfg_dbl_i = 1'b0;
        for (int c = 0; c < 16; c++) begin
            cfg_ocd_code_i = c[3:0];
            // R5: overcurrent delay
            measure(0, 1, OC_BASE + c * OC_STEP, "R5 ocd delay");
        end

        // R11: sparse ticks, one every three cycles
        for (int c = 0; c < 6; c++) begin
            cfg_scd_code_i = c[3:0];
            measure(1, 3, c * SC_STEP, "R11 sparse tick");
        end
        cfg_ocd_code_i = 4'd1;
        measure(0, 3, OC_BASE + OC_STEP, "R11 sparse tick ocd");

        // R6: abort one tick short, then full limit again
        cfg_ocd_code_i = 4'd3;
        @(negedge clk);
        flag_i[0] = 1'b1;
        tick_i = 1'b1;
        repeat (OC_BASE + 3 * OC_STEP - 1) @(negedge clk);
        check("R6 no early fault", int'(fault_o[0]), 0);
        flag_i[0] = 1'b0;
        @(negedge clk);
        check("R6 no fault after drop", int'(fault_o[0]), 0);
        measure(0, 1, OC_BASE + 3 * OC_STEP, "R6 full limit again");

        // R7: clear while flag high is ignored; latch holds without clear
        cfg_scc_code_i = 4'd0;
        @(negedge clk);
        flag_i[2] = 1'b1;
        @(negedge clk);
        check("R7 latched", int'(fault_o[2]), 1);
        clr_i[2] = 1'b1;
        @(negedge clk);
        clr_i[2] = 1'b0;
        check("R7 clear ignored with flag", int'(fault_o[2]), 1);
        flag_i[2] = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 holds without clear", int'(fault_o[2]), 1);
        check("R8 chg_en held low", int'(chg_en_o), 0);
        clr_i[2] = 1'b1;
        @(negedge clk);
        clr_i[2] = 1'b0;
        check("R7 cleared by strobe", int'(fault_o[2]), 0);

        // R9 / R10: threshold exports
        for (int r = 0; r < 2; r++) begin
            cfg_range_i = r[0];
            for (int k = 0; k < 16; k++) begin
                cfg_ocd_thr_i = k[3:0];
                @(negedge clk);
                check("R9 ocd thr", int'(ocd_thr_mv_o), (r == 0) ? 50 + 10 * k : 25 + 5 * k);
            end
            for (int k = 0; k < 8; k++) begin
                cfg_scc_thr_i = k[2:0];
                @(negedge clk);
                check("R10 scc thr", int'(scc_thr_mv_o),
                      (r == 0) ? 100 + 50 * ((k > 4) ? 4 : k) : 50 + 25 * k);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule